// File: doc/BRIEF.md
# Serial Memory Command Sequencer

The block takes one serial-memory operation descriptor at a time and turns it into an ordered series of 32-bit command entries for a downstream command queue. Each entry leaves over a valid/ready stream, one per handshake. The descriptor carries:

- an opcode;
- up to four address bytes and their count;
- a count of dummy bytes;
- a data length and a data direction;
- a lane width for each phase: command, address, dummy and data.

Every operation produces entries in a fixed order. First a chip-select-on entry, then the opcode, then the address bytes, then an optional dummy entry, then zero or more data-length entries, and last a chip-select-off entry. A data length above 255 cannot fit in one 8-bit immediate. The block splits it into power-of-two "exponent" entries, one for each set bit from bit 8 upward, scanning one bit per clock. It then emits one immediate entry for the low remainder. The block only builds entries. Executing them and moving data words happen downstream.

Top module: `spi_op_sequencer`

Entry layout, as decoded downstream:

| Bits | Field |
|------|-------|
| [7:0] | immediate |
| [8] | data-transfer flag |
| [9] | exponent flag |
| [11:10] | lane mode |
| [12] | lower chip select |
| [14] | lower bus |
| [16] | transmit |
| [17] | receive |

All other bits are zero.

## Requirements
- R1: The first entry of every operation is 0x00005405: lower bus, lower chip select, lane mode 1 and immediate 5.
- R2: The second entry is the opcode entry: lower bus and chip select, transmit bit 16 set, lane mode from the command lane width, and the opcode in the immediate.
- R3: One transmit entry follows per address byte, most significant byte first, with mode from the address lane width. The byte count comes from `op_addr_bytes`, and values above 4 are treated as 4.
- R4: A nonzero dummy count adds one entry. In it the data-transfer bit 8 is set, transmit and receive are clear, and the immediate is dummy_bytes*8 divided by the dummy lane width. An unsupported width divides by 1.
- R5: While the remaining data length exceeds 255, the block emits an entry with exponent bit 9 set and immediate k. Here k is the lowest set bit of the remaining length at or above bit 8. The remaining length then drops by 2^k.
- R6: When the remaining length is between 1 and 255, the block emits one entry with exponent bit 9 clear and the remaining length as immediate. That entry ends the data phase.
- R7: Lane widths 1, 2 and 4 give mode codes 1, 2 and 3 in bits [11:10]. Any other width gives code 1.
- R8: Data entries set bit 8 with receive bit 17 when `op_dir` is 1, or with transmit bit 16 when `op_dir` is 2. When `op_dir` is 0 or 3, or the length is 0, there is no data phase.
- R9: The last entry of every operation is 0x00004005: lower bus only, immediate 5. `busy` falls in the cycle after that entry is taken.
- R10: While `ent_valid` is high and `ent_ready` is low, `ent_valid` stays high and `ent_data` stays unchanged.
- R11: `busy` rises the cycle after a descriptor is accepted, and `op_ready` equals not-busy. A descriptor presented while busy is not taken and does not alter the entries of the operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Descriptor offered |
| op_ready | output | 1 | Descriptor can be taken (block idle) |
| op_opcode | input | 8 | Command opcode |
| op_addr | input | 32 | Address value, right-aligned |
| op_addr_bytes | input | 3 | Address byte count (clamped to 4) |
| op_dummy_bytes | input | 5 | Dummy byte count |
| op_dir | input | 2 | 0 none, 1 read, 2 write, 3 none |
| op_cmd_lanes | input | 3 | Lane width of opcode phase |
| op_addr_lanes | input | 3 | Lane width of address phase |
| op_dummy_lanes | input | 3 | Lane width of dummy phase |
| op_data_lanes | input | 3 | Lane width of data phase |
| op_data_len | input | 32 | Data length in bytes |
| busy | output | 1 | Operation in progress |
| ent_valid | output | 1 | Entry offered |
| ent_ready | input | 1 | Downstream takes entry |
| ent_data | output | 32 | Command entry |

## Verification
Two things can coincide in one cycle: the handshake of the chip-select-off entry, and a new descriptor that is already being offered. To provoke this, the bench issues descriptors back to back, so the next one is held on the input with different fields for the whole of the previous operation. The scoreboard then expects the first operation's entries to be unchanged, `busy` to drop after the closing entry, and the new sequence to start intact. The irregular `ent_ready` pattern also lands stalls on cycles where the exponent scan is stepping. Each stalled entry is checked to hold its value.

// File: rtl/seq_pkg.sv
// Shared constants and types of the serial memory command sequencer.
// Assumes 32-bit entries with an 8-bit immediate in the low byte.
package seq_pkg;
    localparam int ENTRY_W    = 32;
    localparam int IMM_W      = 8;
    localparam int DUMMY_W    = IMM_W - 3;
    localparam int LANE_W     = 3;
    localparam int NUM_PHASES = 4;

    // Entry field positions (decoded by the downstream queue consumer)
    localparam int BIT_XFER   = 8;
    localparam int BIT_EXP    = 9;
    localparam int MODE_LSB   = 10;
    localparam int BIT_CS_LO  = 12;
    localparam int BIT_BUS_LO = 14;
    localparam int BIT_TX     = 16;
    localparam int BIT_RX     = 17;

    localparam logic [IMM_W-1:0] CS_HOLD_IMM = 8'd5;
    localparam logic [1:0]       MODE_SINGLE = 2'd1;

    localparam logic [1:0] DIR_IN  = 2'd1;
    localparam logic [1:0] DIR_OUT = 2'd2;

    localparam int PH_CMD   = 0;
    localparam int PH_ADDR  = 1;
    localparam int PH_DUMMY = 2;
    localparam int PH_DATA  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CSON,
        ST_OPC,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_CSOFF
    } seq_state_t;
endpackage

// File: rtl/lane_mode_enc.sv
// Maps a lane width (1, 2, 4) to the 2-bit mode code of an entry.
// Assumes nothing about the input; unsupported widths fall back to single lane.
module lane_mode_enc
    import seq_pkg::*;
(
    input  logic [LANE_W-1:0] lanes_i,
    output logic [1:0]        mode_o
);
    // Width-to-code mapping with single-lane fallback
    always_comb begin
        case (lanes_i)
            3'd2:    mode_o = 2'd2;
            3'd4:    mode_o = 2'd3;
            default: mode_o = MODE_SINGLE;
        endcase
        // R7
        mode_nonzero_chk: assert (mode_o != 2'b00)
            else $error("lane mode code zero");
    end
endmodule

// File: rtl/len_splitter.sv
// Splits a data length into exponent chunks (one per set bit at or above
// IMM_W, lowest first) followed by one immediate chunk for the remainder.
// Assumes load and take never coincide; scans one bit position per clock.
module len_splitter
    import seq_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             take,
    output logic             chunk_valid,
    output logic             chunk_exp,
    output logic [IMM_W-1:0] chunk_imm,
    output logic             empty
);
    localparam int EXP_W = $clog2(LEN_W);

    logic [LEN_W-1:0] rem_q;
    logic [EXP_W-1:0] bit_q;
    logic             big;

    // Length above the immediate range still has high bits set
    always_comb begin
        big         = |rem_q[LEN_W-1:IMM_W];
        empty       = (rem_q == '0);
        chunk_exp   = big;
        chunk_valid = !empty && (!big || rem_q[bit_q]);
        chunk_imm   = big ? IMM_W'(bit_q) : rem_q[IMM_W-1:0];
    end

    // Remaining length and scan position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            bit_q <= EXP_W'(IMM_W);
        end else if (load) begin
            rem_q <= load_len;
            bit_q <= EXP_W'(IMM_W);
        end else if (take) begin
            if (big) begin
                rem_q <= rem_q - (LEN_W'(1) << bit_q);
                bit_q <= bit_q + 1'b1;
            end else begin
                rem_q <= '0;
            end
        end else if (big && !rem_q[bit_q]) begin
            bit_q <= bit_q + 1'b1;
        end
    end

    // R5
    exp_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && chunk_exp |=> rem_q < $past(rem_q));
    // R6
    imm_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !chunk_exp |=> empty);
endmodule

// File: rtl/seq_ctrl.sv
// Phase controller: walks chip-select-on, opcode, address, dummy, data and
// chip-select-off, advancing on each entry handshake.
// Assumes addr_cnt is already clamped and data_done reflects the splitter.
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int CNT_W = 3,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] addr_cnt,
    input  logic             has_dummy,
    input  logic             data_done,
    input  logic             take,
    output seq_state_t       state_o,
    output logic [IDX_W-1:0] addr_idx_o,
    output logic             busy_o
);
    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             last_addr;

    // Next phase selection
    always_comb begin
        state_d   = state_q;
        idx_d     = idx_q;
        last_addr = (CNT_W'(idx_q) + CNT_W'(1)) == addr_cnt;
        case (state_q)
            ST_IDLE:  if (start) state_d = ST_CSON;
            ST_CSON:  if (take) state_d = ST_OPC;
            ST_OPC: if (take) begin
                idx_d = '0;
                if (addr_cnt != '0) state_d = ST_ADDR;
                else if (has_dummy) state_d = ST_DUMMY;
                else                state_d = ST_DATA;
            end
            ST_ADDR: if (take) begin
                if (last_addr) state_d = has_dummy ? ST_DUMMY : ST_DATA;
                else           idx_d = idx_q + 1'b1;
            end
            ST_DUMMY: if (take) state_d = ST_DATA;
            ST_DATA:  if (data_done) state_d = ST_CSOFF;
            ST_CSOFF: if (take) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Phase and address index registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    assign state_o    = state_q;
    assign addr_idx_o = idx_q;
    assign busy_o     = (state_q != ST_IDLE);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && !start |=> state_q == ST_IDLE);
    // R9
    close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_CSOFF && take |=> state_q == ST_IDLE);
endmodule

// File: rtl/entry_fmt.sv
// Composes the 32-bit entry for the current phase from latched descriptor
// fields, lane modes and the splitter chunk. Purely combinational.
// Assumes mode codes are 1..3 (encoder guarantees it).
module entry_fmt
    import seq_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int CNT_W      = 3,
    parameter int IDX_W      = 2
) (
    input  seq_state_t                state,
    input  logic [7:0]                opcode,
    input  logic [8*ADDR_BYTES-1:0]   addr,
    input  logic [CNT_W-1:0]          addr_cnt,
    input  logic [IDX_W-1:0]          addr_idx,
    input  logic [DUMMY_W-1:0]        dummy,
    input  logic [1:0]                dir,
    input  logic [1:0]                mode_cmd,
    input  logic [1:0]                mode_addr,
    input  logic [1:0]                mode_dummy,
    input  logic [1:0]                mode_data,
    input  logic                      chunk_valid,
    input  logic                      chunk_exp,
    input  logic [IMM_W-1:0]          chunk_imm,
    output logic                      valid,
    output logic [ENTRY_W-1:0]        entry
);
    logic [CNT_W-1:0]   byte_sel;
    logic [7:0]         addr_byte;
    logic [IMM_W-1:0]   dummy_x8;
    logic [IMM_W-1:0]   dummy_imm;
    logic [ENTRY_W-1:0] base;

    // Address byte picked most significant first
    always_comb begin
        byte_sel  = addr_cnt - CNT_W'(1) - CNT_W'(addr_idx);
        addr_byte = '0;
        for (int b = 0; b < ADDR_BYTES; b++) begin
            if (byte_sel == CNT_W'(b)) addr_byte = addr[8*b +: 8];
        end
    end

    // Dummy cycle count: bytes*8 shifted down by log2 of lane width
    always_comb begin
        dummy_x8  = {dummy, 3'b000};
        dummy_imm = dummy_x8 >> (mode_dummy - 2'd1);
    end

    // Entry assembly per phase
    always_comb begin
        base              = '0;
        base[BIT_BUS_LO]  = 1'b1;
        base[BIT_CS_LO]   = 1'b1;
        entry             = '0;
        valid             = 1'b0;
        case (state)
            ST_CSON: begin
                valid                    = 1'b1;
                entry                    = base;
                entry[MODE_LSB +: 2]     = MODE_SINGLE;
                entry[IMM_W-1:0]         = CS_HOLD_IMM;
            end
            ST_OPC: begin
                valid                    = 1'b1;
                entry                    = base;
                entry[MODE_LSB +: 2]     = mode_cmd;
                entry[BIT_TX]            = 1'b1;
                entry[IMM_W-1:0]         = opcode;
            end
            ST_ADDR: begin
                valid                    = 1'b1;
                entry                    = base;
                entry[MODE_LSB +: 2]     = mode_addr;
                entry[BIT_TX]            = 1'b1;
                entry[IMM_W-1:0]         = addr_byte;
            end
            ST_DUMMY: begin
                valid                    = 1'b1;
                entry                    = base;
                entry[MODE_LSB +: 2]     = mode_dummy;
                entry[BIT_XFER]          = 1'b1;
                entry[IMM_W-1:0]         = dummy_imm;
            end
            ST_DATA: begin
                valid                    = chunk_valid;
                entry                    = base;
                entry[MODE_LSB +: 2]     = mode_data;
                entry[BIT_XFER]          = 1'b1;
                entry[BIT_TX]            = (dir == DIR_OUT);
                entry[BIT_RX]            = (dir == DIR_IN);
                entry[BIT_EXP]           = chunk_exp;
                entry[IMM_W-1:0]         = chunk_imm;
            end
            ST_CSOFF: begin
                valid                    = 1'b1;
                entry[BIT_BUS_LO]        = 1'b1;
                entry[IMM_W-1:0]         = CS_HOLD_IMM;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_op_sequencer.sv
// Top of the serial memory command sequencer. Latches a descriptor when
// idle, then emits its entries over a valid/ready stream.
// Assumes the consumer may stall at any cycle; a new descriptor waits
// until the closing entry of the current one has been taken.
module spi_op_sequencer
    import seq_pkg::*;
#(
    parameter int LEN_W      = 32,
    parameter int ADDR_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_valid,
    output logic                    op_ready,
    input  logic [7:0]              op_opcode,
    input  logic [8*ADDR_BYTES-1:0] op_addr,
    input  logic [2:0]              op_addr_bytes,
    input  logic [DUMMY_W-1:0]      op_dummy_bytes,
    input  logic [1:0]              op_dir,
    input  logic [LANE_W-1:0]       op_cmd_lanes,
    input  logic [LANE_W-1:0]       op_addr_lanes,
    input  logic [LANE_W-1:0]       op_dummy_lanes,
    input  logic [LANE_W-1:0]       op_data_lanes,
    input  logic [LEN_W-1:0]        op_data_len,
    output logic                    busy,
    output logic                    ent_valid,
    input  logic                    ent_ready,
    output logic [ENTRY_W-1:0]      ent_data
);
    localparam int CNT_W = 3;
    localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    logic                    start, take, data_take;
    seq_state_t              state;
    logic [IDX_W-1:0]        addr_idx;
    logic [7:0]              opc_q;
    logic [8*ADDR_BYTES-1:0] addr_q;
    logic [CNT_W-1:0]        acnt_q;
    logic [DUMMY_W-1:0]      dummy_q;
    logic [1:0]              dir_q;
    logic [LANE_W-1:0]       lane_q [NUM_PHASES];
    logic [1:0]              mode_w [NUM_PHASES];
    logic                    has_data;
    logic                    chunk_valid, chunk_exp, data_done;
    logic [IMM_W-1:0]        chunk_imm;

    // Handshake qualifiers
    always_comb begin
        op_ready  = !busy;
        start     = op_valid && op_ready;
        take      = ent_valid && ent_ready;
        data_take = take && (state == ST_DATA);
        has_data  = (op_dir == DIR_IN) || (op_dir == DIR_OUT);
    end

    // Descriptor capture on accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opc_q   <= '0;
            addr_q  <= '0;
            acnt_q  <= '0;
            dummy_q <= '0;
            dir_q   <= '0;
            for (int p = 0; p < NUM_PHASES; p++) lane_q[p] <= LANE_W'(1);
        end else if (start) begin
            opc_q   <= op_opcode;
            addr_q  <= op_addr;
            acnt_q  <= (op_addr_bytes > CNT_W'(ADDR_BYTES)) ? CNT_W'(ADDR_BYTES)
                                                            : op_addr_bytes;
            dummy_q <= op_dummy_bytes;
            dir_q   <= op_dir;
            lane_q[PH_CMD]   <= op_cmd_lanes;
            lane_q[PH_ADDR]  <= op_addr_lanes;
            lane_q[PH_DUMMY] <= op_dummy_lanes;
            lane_q[PH_DATA]  <= op_data_lanes;
        end
    end

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_mode
        lane_mode_enc u_enc (
            .lanes_i (lane_q[g]),
            .mode_o  (mode_w[g])
        );
    end

    len_splitter #(.LEN_W(LEN_W)) u_split (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (start),
        .load_len    (has_data ? op_data_len : '0),
        .take        (data_take),
        .chunk_valid (chunk_valid),
        .chunk_exp   (chunk_exp),
        .chunk_imm   (chunk_imm),
        .empty       (data_done)
    );

    seq_ctrl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .addr_cnt   (acnt_q),
        .has_dummy  (dummy_q != '0),
        .data_done  (data_done),
        .take       (take),
        .state_o    (state),
        .addr_idx_o (addr_idx),
        .busy_o     (busy)
    );

    entry_fmt #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_fmt (
        .state       (state),
        .opcode      (opc_q),
        .addr        (addr_q),
        .addr_cnt    (acnt_q),
        .addr_idx    (addr_idx),
        .dummy       (dummy_q),
        .dir         (dir_q),
        .mode_cmd    (mode_w[PH_CMD]),
        .mode_addr   (mode_w[PH_ADDR]),
        .mode_dummy  (mode_w[PH_DUMMY]),
        .mode_data   (mode_w[PH_DATA]),
        .chunk_valid (chunk_valid),
        .chunk_exp   (chunk_exp),
        .chunk_imm   (chunk_imm),
        .valid       (ent_valid),
        .entry       (ent_data)
    );

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ent_valid);
    // R9
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(take) && !$past(ent_data[BIT_CS_LO]));
    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid && !ent_ready |=> ent_valid && $stable(ent_data));
    // R8
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> !(ent_data[BIT_TX] && ent_data[BIT_RX]));
endmodule

// File: tb/tb_spi_op_sequencer.sv
module tb_spi_op_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 50000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic        op_ready;
    logic [7:0]  op_opcode;
    logic [31:0] op_addr;
    logic [2:0]  op_addr_bytes;
    logic [4:0]  op_dummy_bytes;
    logic [1:0]  op_dir;
    logic [2:0]  op_cmd_lanes, op_addr_lanes, op_dummy_lanes, op_data_lanes;
    logic [31:0] op_data_len;
    logic        busy;
    logic        ent_valid;
    logic        ent_ready;
    logic [31:0] ent_data;

    int compared   = 0;
    int mismatched = 0;
    int cyc        = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    spi_op_sequencer dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_opcode(op_opcode), .op_addr(op_addr), .op_addr_bytes(op_addr_bytes),
        .op_dummy_bytes(op_dummy_bytes), .op_dir(op_dir),
        .op_cmd_lanes(op_cmd_lanes), .op_addr_lanes(op_addr_lanes),
        .op_dummy_lanes(op_dummy_lanes), .op_data_lanes(op_data_lanes),
        .op_data_len(op_data_len), .busy(busy), .ent_valid(ent_valid),
        .ent_ready(ent_ready), .ent_data(ent_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] mode_of(input int w);
        if (w == 2) return 32'd2 << 10;
        if (w == 4) return 32'd3 << 10;
        return 32'd1 << 10;
    endfunction

    task automatic push(input logic [31:0] v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    task automatic check(input bit ok, input string t, input logic [31:0] act,
                         input logic [31:0] expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", t, act, expv);
        end
    endtask

    // Driver: builds the expected entries, then offers the descriptor
    task automatic send(input logic [7:0] opc, input logic [31:0] adr,
                        input int nb, input int dmy, input int dir,
                        input int cl, input int al, input int dl, input int xl,
                        input logic [31:0] len);
        int         n;
        int         div;
        logic [32:0] rem;
        logic [31:0] base;
        push(32'h0000_5405, "R1");
        push(32'h0001_5000 | mode_of(cl) | 32'(opc), "R2 R7");
        n = (nb > 4) ? 4 : nb;
        for (int i = 0; i < n; i++)
            push(32'h0001_5000 | mode_of(al) | ((adr >> (8*(n-1-i))) & 32'hFF), "R3");
        if (dmy != 0) begin
            div = (dl == 2) ? 2 : (dl == 4) ? 4 : 1;
            push(32'h0000_5100 | mode_of(dl) | 32'((dmy*8)/div), "R4");
        end
        if (len != 0 && (dir == 1 || dir == 2)) begin
            base = 32'h0000_5100 | mode_of(xl) | ((dir == 1) ? 32'h2_0000 : 32'h1_0000);
            rem  = {1'b0, len};
            while (rem > 255) begin
                for (int k = 8; k < 32; k++) begin
                    if (rem[k]) begin
                        push(base | 32'h200 | 32'(k), "R5 R8");
                        rem = rem - (33'd1 << k);
                        break;
                    end
                end
            end
            if (rem != 0) push(base | 32'(rem[7:0]), "R6 R8");
        end
        push(32'h0000_4005, "R9");

        @(negedge clk);
        op_opcode = opc; op_addr = adr; op_addr_bytes = 3'(nb);
        op_dummy_bytes = 5'(dmy); op_dir = 2'(dir);
        op_cmd_lanes = 3'(cl); op_addr_lanes = 3'(al);
        op_dummy_lanes = 3'(dl); op_data_lanes = 3'(xl);
        op_data_len = len; op_valid = 1'b1;
        while (cyc < LIMIT) begin
            #(CLK_PERIOD/4);
            if (op_ready) break;
            @(negedge clk);
        end
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // Monitor: drives ready pattern, pops and compares taken entries
    initial begin
        logic        prev_stall = 1'b0;
        logic [31:0] prev_data  = '0;
        logic        after_close = 1'b0;
        logic [31:0] e;
        string       t;
        ent_ready = 1'b0;
        forever begin
            @(negedge clk);
            ent_ready = rst_n && ((cyc % 5) != 2) && ((cyc % 7) != 0);
            #(CLK_PERIOD/4);
            if (rst_n) begin
                if (after_close)   // R11: busy low after closing entry taken
                    check(!busy, "R11 busy after close", 32'(busy), 32'd0);
                if (prev_stall)    // R10: held while stalled
                    check(ent_valid && ent_data == prev_data, "R10 stall hold",
                          ent_data, prev_data);
                after_close = 1'b0;
                if (ent_valid && ent_ready) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R9 unexpected entry", ent_data, 32'h0);
                    end else begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(ent_data == e, t, ent_data, e);
                    end
                    after_close = (ent_data == 32'h0000_4005);
                end
                prev_stall = ent_valid && !ent_ready;
                prev_data  = ent_data;
            end
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_opcode = '0; op_addr = '0;
        op_addr_bytes = '0; op_dummy_bytes = '0; op_dir = '0;
        op_cmd_lanes = 3'd1; op_addr_lanes = 3'd1; op_dummy_lanes = 3'd1;
        op_data_lanes = 3'd1; op_data_len = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        // R11: reset state
        check(!busy, "R11 reset busy", 32'(busy), 32'd0);
        check(!ent_valid, "R11 reset ent_valid", 32'(ent_valid), 32'd0);
        check(op_ready, "R11 reset op_ready", 32'(op_ready), 32'd1);

        // Read, single lanes, 1 dummy byte, short length
        send(8'h0B, 32'h0012_3456, 3, 1, 1, 1, 1, 1, 1, 32'd16);
        // Quad write, length 0x30A -> exp 8, exp 9, imm 10 (R5, R6)
        send(8'h32, 32'h00AB_CDEF, 3, 0, 2, 1, 1, 1, 4, 32'h30A);
        // Dual command/address, quad dummy, single exponent chunk
        send(8'hEC, 32'hA1B2_C3D4, 4, 4, 1, 2, 2, 4, 2, 32'h1_0000);
        // No data direction, unsupported command width (R7, R8)
        send(8'h06, 32'h0, 0, 0, 0, 3, 1, 1, 1, 32'd100);
        // Address count clamp, dummy width 3, zero length (R3, R4, R8)
        send(8'h9F, 32'h1122_3344, 7, 2, 1, 1, 4, 3, 1, 32'd0);
        // Boundaries: 255 immediate only, 256 exponent only (R6, R5)
        send(8'h03, 32'h55, 1, 0, 1, 1, 1, 1, 1, 32'd255);
        send(8'h02, 32'h66, 2, 0, 2, 1, 1, 1, 2, 32'd256);
        // Full length: exponents 8..31 then 255; dual dummy
        send(8'h6B, 32'h77, 1, 31, 1, 4, 4, 2, 4, 32'hFFFF_FFFF);
        // Direction code 3 means no data (R8)
        send(8'hAB, 32'h88, 1, 0, 3, 1, 1, 1, 1, 32'd50);

        while ((exp_q.size() != 0 || busy) && cyc < LIMIT) @(negedge clk);
        if (cyc >= LIMIT) begin
            compared++;
            mismatched++;
            $display("FAIL R10 watchdog: pending %0d expected 0", exp_q.size());
        end
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule